// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor core whose register namespace is split into overlapping windows. A 5-bit register number from an instruction is turned into a physical storage slot through a current-window pointer. Eight registers are common to every window, eight belong to one window only, and sixteen sit in groups that two adjacent windows share. Through that shared group a caller's outgoing arguments turn up as the callee's incoming arguments, with no copying.

Two combinational read ports and one clocked write port serve the datapath. A save request moves to the next window down and a restore request moves back up, each with wraparound. A per-window invalid mask marks windows whose contents have not been spilled or filled yet. A save or restore that would land on such a window is refused and reported on a one-cycle trap output instead. Software can load the pointer and the mask directly, so a trap handler can adjust them before the faulting operation is retried. Spilling to memory and the handlers themselves are outside this block.

Top module: `rwin_regfile`

## Requirements
- R1: During and right after reset, `cwp_out` is 0, `wim_out` is 0, and both `ovf_trap` and `unf_trap` are 0.
- R2: Register number 0 always reads as zero on both read ports, and a write addressed to it changes no register.
- R3: Register numbers 1-7 name one set of registers shared by every window. Numbers 16-23 name registers private to the current window. The group is chosen by bits [4:3] of the number: 00 shared, 01 outgoing, 10 private, 11 incoming.
- R4: Outgoing registers 8-15 of window N are the same storage as incoming registers 24-31 of window (N-1) mod NWIN, at the same offset within the group.
- R5: A save request whose target window (cwp-1) mod NWIN has mask bit 0 sets `cwp_out` to that target on the next cycle, and no trap is raised.
- R6: A restore request whose target window (cwp+1) mod NWIN has mask bit 0 sets `cwp_out` to that target on the next cycle, and no trap is raised.
- R7: A save request whose target window has mask bit 1 leaves `cwp_out` unchanged and raises `ovf_trap` for exactly the following cycle.
- R8: A restore request whose target window has mask bit 1 leaves `cwp_out` unchanged and raises `unf_trap` for exactly the following cycle.
- R9: When `sw_we` is high, `sw_cwp` and `sw_mask` are loaded on the next edge. Any save or restore in that cycle is ignored and raises no trap. Mask bits at positions NWIN and above always read as 0.
- R10: When save and restore are requested in the same cycle, the save is performed and the restore is ignored.
- R11: A register write in the same cycle as a save or restore goes to the window that was current before the move. Reads always use the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Register number, read port A |
| rd_a_data | output | XLEN | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Register number, read port B |
| rd_b_data | output | XLEN | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Register number for the write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Move to the next lower window |
| restore_req | input | 1 | Move to the next higher window |
| sw_we | input | 1 | Load the pointer and the mask directly |
| sw_cwp | input | $clog2(NWIN) | Pointer value to load |
| sw_mask | input | 32 | Mask value to load |
| cwp_out | output | $clog2(NWIN) | Current window pointer |
| wim_out | output | 32 | Invalid-window mask, upper bits zero |
| ovf_trap | output | 1 | Save refused, one-cycle pulse |
| unf_trap | output | 1 | Restore refused, one-cycle pulse |

## Verification
The bench builds the block with NWIN = 4 and XLEN = 32, so the whole physical storage of 72 entries can be filled and read back through all 32 register numbers in every window. With four windows, saves and restores can step through every pointer value, including both wraparound points. The trap sweep then places a single invalid bit ahead of and behind each pointer value in turn. A 32-bit mask load against four live bits also exercises the zeroing of the unused upper positions.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int unsigned MASK_W     = 32;
  localparam int unsigned ARCH_IDX_W = 5;
  localparam int unsigned SHARED_N   = 8;
  localparam int unsigned PER_WIN_N  = 16;

  typedef enum logic [1:0] {
    GRP_SHARED = 2'd0,
    GRP_OUTGO  = 2'd1,
    GRP_PRIV   = 2'd2,
    GRP_INCOM  = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/rwin_map.sv
module rwin_map
  import rwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned PW   = $clog2(NWIN),
  parameter int unsigned PIW  = $clog2(SHARED_N + PER_WIN_N * NWIN)
) (
  input  logic [PW-1:0]         cwp,
  input  logic [ARCH_IDX_W-1:0] arch_idx,
  output logic [PIW-1:0]        phys_idx,
  output logic                  is_zero
);
  reg_grp_e      grp;
  logic [PW-1:0] win;
  logic          upper_half;

  always_comb begin
    grp        = reg_grp_e'(arch_idx[4:3]);
    win        = cwp;
    upper_half = 1'b1;
    case (grp)
      GRP_OUTGO: win        = cwp - 1'b1;
      GRP_PRIV:  upper_half = 1'b0;
      default:   ;
    endcase
    if (grp == GRP_SHARED)
      phys_idx = PIW'(arch_idx[2:0]);
    else
      phys_idx = PIW'(SHARED_N) + PIW'({win, upper_half, arch_idx[2:0]});
  end

  assign is_zero = (arch_idx == '0);
endmodule

// File: rtl/rwin_wctl.sv
module rwin_wctl
  import rwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned PW   = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_req,
  input  logic              restore_req,
  input  logic              sw_we,
  input  logic [PW-1:0]     sw_cwp,
  input  logic [MASK_W-1:0] sw_mask,
  output logic [PW-1:0]     cwp,
  output logic [MASK_W-1:0] wim,
  output logic              ovf,
  output logic              unf
);
  logic [PW-1:0]   cwp_q, cwp_d, tgt_dn, tgt_up;
  logic [NWIN-1:0] mask_q, mask_d;
  logic            ovf_q, ovf_d, unf_q, unf_d;
  logic            state_en;

  assign tgt_dn   = cwp_q - 1'b1;
  assign tgt_up   = cwp_q + 1'b1;
  assign state_en = sw_we | save_req | restore_req;

  always_comb begin
    cwp_d  = cwp_q;
    mask_d = mask_q;
    ovf_d  = 1'b0;
    unf_d  = 1'b0;
    if (sw_we) begin
      cwp_d  = sw_cwp;
      mask_d = sw_mask[NWIN-1:0];
    end else if (save_req) begin
      if (mask_q[tgt_dn]) ovf_d = 1'b1;
      else                cwp_d = tgt_dn;
    end else if (restore_req) begin
      if (mask_q[tgt_up]) unf_d = 1'b1;
      else                cwp_d = tgt_up;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q  <= '0;
      mask_q <= '0;
    end else if (state_en) begin
      cwp_q  <= cwp_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  always_comb begin
    wim            = '0;
    wim[NWIN-1:0]  = mask_q;
  end

  assign cwp = cwp_q;
  assign ovf = ovf_q;
  assign unf = unf_q;
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned DEPTH = 136,
  parameter int unsigned NRD   = 2,
  parameter int unsigned PIW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [PIW-1:0]            wr_idx,
  input  logic [XLEN-1:0]           wr_data,
  input  logic [NRD-1:0][PIW-1:0]   rd_idx,
  input  logic [NRD-1:0]            rd_zero,
  output logic [NRD-1:0][XLEN-1:0]  rd_data
);
  logic [XLEN-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_data;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = rd_zero[p] ? '0 : cells[rd_idx[p]];
  end
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [4:0]              rd_a_idx,
  output logic [XLEN-1:0]         rd_a_data,
  input  logic [4:0]              rd_b_idx,
  output logic [XLEN-1:0]         rd_b_data,
  input  logic                    wr_en,
  input  logic [4:0]              wr_idx,
  input  logic [XLEN-1:0]         wr_data,
  input  logic                    save_req,
  input  logic                    restore_req,
  input  logic                    sw_we,
  input  logic [$clog2(NWIN)-1:0] sw_cwp,
  input  logic [31:0]             sw_mask,
  output logic [$clog2(NWIN)-1:0] cwp_out,
  output logic [31:0]             wim_out,
  output logic                    ovf_trap,
  output logic                    unf_trap
);
  localparam int unsigned PW     = $clog2(NWIN);
  localparam int unsigned DEPTH  = SHARED_N + PER_WIN_N * NWIN;
  localparam int unsigned PIW    = $clog2(DEPTH);
  localparam int unsigned NRD    = 2;
  localparam int unsigned NMAP   = NRD + 1;

  logic [NMAP-1:0][ARCH_IDX_W-1:0] map_arch;
  logic [NMAP-1:0][PIW-1:0]        map_phys;
  logic [NMAP-1:0]                 map_zero;
  logic [NRD-1:0][XLEN-1:0]        rd_bus;
  logic [PW-1:0]                   cwp;
  logic                            wr_commit;

  assign map_arch[0] = rd_a_idx;
  assign map_arch[1] = rd_b_idx;
  assign map_arch[2] = wr_idx;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    rwin_map #(.NWIN(NWIN), .PW(PW), .PIW(PIW)) map_i (
      .cwp      (cwp),
      .arch_idx (map_arch[m]),
      .phys_idx (map_phys[m]),
      .is_zero  (map_zero[m])
    );
  end

  rwin_wctl #(.NWIN(NWIN), .PW(PW)) wctl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .sw_we       (sw_we),
    .sw_cwp      (sw_cwp),
    .sw_mask     (sw_mask),
    .cwp         (cwp),
    .wim         (wim_out),
    .ovf         (ovf_trap),
    .unf         (unf_trap)
  );

  assign wr_commit = wr_en & ~map_zero[2];

  rwin_store #(.XLEN(XLEN), .DEPTH(DEPTH), .NRD(NRD), .PIW(PIW)) store_i (
    .clk     (clk),
    .wr_en   (wr_commit),
    .wr_idx  (map_phys[2]),
    .wr_data (wr_data),
    .rd_idx  (map_phys[NRD-1:0]),
    .rd_zero (map_zero[NRD-1:0]),
    .rd_data (rd_bus)
  );

  assign rd_a_data = rd_bus[0];
  assign rd_b_data = rd_bus[1];
  assign cwp_out   = cwp;
endmodule

// File: rtl/rwin_checker.sv
module rwin_checker #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [4:0]              rd_a_idx,
  input logic [XLEN-1:0]         rd_a_data,
  input logic [4:0]              rd_b_idx,
  input logic [XLEN-1:0]         rd_b_data,
  input logic                    wr_en,
  input logic [4:0]              wr_idx,
  input logic [XLEN-1:0]         wr_data,
  input logic                    save_req,
  input logic                    restore_req,
  input logic                    sw_we,
  input logic [$clog2(NWIN)-1:0] sw_cwp,
  input logic [31:0]             sw_mask,
  input logic [$clog2(NWIN)-1:0] cwp_out,
  input logic [31:0]             wim_out,
  input logic                    ovf_trap,
  input logic                    unf_trap
);
  localparam int unsigned PW = $clog2(NWIN);
  logic [PW-1:0] below, above;
  assign below = cwp_out - 1'b1;
  assign above = cwp_out + 1'b1;

  assert_r0_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_a_idx == 5'd0) |-> (rd_a_data == '0)) and ((rd_b_idx == 5'd0) |-> (rd_b_data == '0)));

  assert_save_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !sw_we && !wim_out[below]) |=> (cwp_out == $past(below)) && !ovf_trap);

  assert_restore_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !sw_we && !wim_out[above]) |=> (cwp_out == $past(above)) && !unf_trap);

  assert_overflow_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !sw_we && wim_out[below]) |=> ovf_trap && $stable(cwp_out));

  assert_underflow_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !sw_we && wim_out[above]) |=> unf_trap && $stable(cwp_out));

  assert_sw_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> (cwp_out == $past(sw_cwp)) && !ovf_trap && !unf_trap);

  assert_mask_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wim_out >> NWIN) == 32'd0);

  assert_save_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req) |=> !unf_trap);
endmodule

bind rwin_regfile rwin_checker #(.NWIN(NWIN), .XLEN(XLEN)) chk_i (.*);

// File: tb/rwin_regfile_tb_top.sv
module rwin_regfile_tb_top;
  localparam int NW = 4;
  localparam int PW = $clog2(NW);

  logic clk = 1'b0;
  logic rst_n;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, sw_mask, wim_out;
  logic wr_en, save_req, restore_req, sw_we, ovf_trap, unf_trap;
  logic [PW-1:0] sw_cwp, cwp_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_sh [8];
  logic [31:0] m_pv [NW*8];
  logic [31:0] m_in [NW*8];
  int m_cwp;
  logic [31:0] m_mask;

  always #4 clk = ~clk;

  rwin_regfile #(.NWIN(NW), .XLEN(32)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(int w, int r);
    if (r == 0) return 32'd0;
    if (r < 8)  return m_sh[r];
    if (r < 16) return m_in[((w + NW - 1) % NW) * 8 + r - 8];
    if (r < 24) return m_pv[w * 8 + r - 16];
    return m_in[w * 8 + r - 24];
  endfunction

  function automatic string grp_tag(int r);
    if (r == 0) return "R2";
    if (r < 8 || (r >= 16 && r < 24)) return "R3";
    return "R4";
  endfunction

  // one cycle: drive after a falling edge, step to the next falling edge, check state
  task automatic cyc(string req, bit s, bit rs, bit we, int wi, logic [31:0] wd,
                     bit swe, int sc, logic [31:0] sm);
    bit eo, eu;
    int tgt;
    save_req = s; restore_req = rs; wr_en = we; wr_idx = 5'(wi); wr_data = wd;
    sw_we = swe; sw_cwp = PW'(sc); sw_mask = sm;
    if (we && wi != 0) begin
      if (wi < 8)       m_sh[wi] = wd;
      else if (wi < 16) m_in[((m_cwp + NW - 1) % NW) * 8 + wi - 8] = wd;
      else if (wi < 24) m_pv[m_cwp * 8 + wi - 16] = wd;
      else              m_in[m_cwp * 8 + wi - 24] = wd;
    end
    eo = 0; eu = 0;
    if (swe) begin
      m_cwp = sc; m_mask = sm & ((32'd1 << NW) - 1);
    end else if (s) begin
      tgt = (m_cwp + NW - 1) % NW;
      if (m_mask[tgt]) eo = 1; else m_cwp = tgt;
    end else if (rs) begin
      tgt = (m_cwp + 1) % NW;
      if (m_mask[tgt]) eu = 1; else m_cwp = tgt;
    end
    @(negedge clk);
    save_req = 0; restore_req = 0; wr_en = 0; sw_we = 0;
    if (s || rs || swe) begin
      chk(req, 32'(cwp_out), 32'(m_cwp));
      chk(req, {31'd0, ovf_trap}, {31'd0, eo});
      chk(req, {31'd0, unf_trap}, {31'd0, eu});
    end
  endtask

  task automatic rd_chk(string req, int r);
    rd_a_idx = 5'(r); rd_b_idx = 5'(31 - r);
    #1;
    chk(req, rd_a_data, exp_rd(m_cwp, r));
    chk(grp_tag(31 - r), rd_b_data, exp_rd(m_cwp, 31 - r));
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0; wr_en = 0;
    save_req = 0; restore_req = 0; sw_we = 0; sw_cwp = 0; sw_mask = 0;
    m_cwp = 0; m_mask = 0;
    repeat (3) @(negedge clk);
    chk("R1", 32'(cwp_out), 32'd0);
    chk("R1", wim_out, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", 32'(cwp_out), 32'd0);
    chk("R1", wim_out, 32'd0);
    chk("R1", {30'd0, ovf_trap, unf_trap}, 32'd0);

    // fill every register of every window, r0 included
    for (int w = 0; w < NW; w++) begin
      cyc("R9", 0, 0, 0, 0, 0, 1, w, 0);
      for (int r = 0; r < 32; r++)
        cyc("R2", 0, 0, 1, r, {8'hC0 + 8'(w), 8'h5A, 8'(r), 8'(w * 32 + r)}, 0, 0, 0);
    end
    // read back through every number in every window
    for (int w = 0; w < NW; w++) begin
      cyc("R9", 0, 0, 0, 0, 0, 1, w, 0);
      for (int r = 0; r < 32; r++) rd_chk(grp_tag(r), r);
    end

    // explicit overlap: outs of window 2 appear as ins of window 1
    cyc("R9", 0, 0, 0, 0, 0, 1, 2, 0);
    cyc("R4", 0, 0, 1, 11, 32'hDEAD_0B0B, 0, 0, 0);
    cyc("R4", 0, 0, 0, 0, 0, 1, 1, 0);
    rd_chk("R4", 27);
    chk("R4", rd_a_data, 32'hDEAD_0B0B);

    // save sweep through all windows with wrap, then restores back
    cyc("R9", 0, 0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < NW + 1; i++) begin
      cyc("R5", 1, 0, 0, 0, 0, 0, 0, 0);
      for (int r = 24; r < 32; r++) rd_chk("R4", r);
    end
    for (int i = 0; i < NW + 1; i++) cyc("R6", 0, 1, 0, 0, 0, 0, 0, 0);

    // trap sweep: one invalid window below / above each pointer value
    for (int c = 0; c < NW; c++) begin
      cyc("R9", 0, 0, 0, 0, 0, 1, c, 32'd1 << ((c + NW - 1) % NW));
      cyc("R7", 1, 0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      chk("R7", {31'd0, ovf_trap}, 32'd0);
      cyc("R6", 0, 1, 0, 0, 0, 0, 0, 0);
      cyc("R9", 0, 0, 0, 0, 0, 1, c, 32'd1 << ((c + 1) % NW));
      cyc("R8", 0, 1, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      chk("R8", {31'd0, unf_trap}, 32'd0);
      cyc("R5", 1, 0, 0, 0, 0, 0, 0, 0);
    end

    // software load: upper mask bits dropped, save ignored during load
    cyc("R9", 0, 0, 0, 0, 0, 1, 2, 32'hFFFF_FFF0);
    chk("R9", wim_out, 32'd0);
    cyc("R9", 0, 0, 0, 0, 0, 1, 3, 32'hFFFF_FFFF);
    chk("R9", wim_out, 32'h0000_000F);
    cyc("R9", 1, 0, 0, 0, 0, 1, 1, 32'h0000_0001);
    chk("R9", 32'(cwp_out), 32'd1);
    chk("R9", {31'd0, ovf_trap}, 32'd0);

    // save and restore together: save wins
    cyc("R10", 1, 1, 0, 0, 0, 1, 2, 0);
    cyc("R10", 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R10", 32'(cwp_out), 32'd1);

    // write during a move lands in the old window
    cyc("R11", 0, 0, 0, 0, 0, 1, 2, 0);
    cyc("R11", 1, 0, 1, 17, 32'h1234_5678, 0, 0, 0);
    chk("R11", 32'(cwp_out), 32'd1);
    rd_chk("R11", 17);
    cyc("R11", 0, 1, 1, 20, 32'h0BAD_F00D, 0, 0, 0);
    rd_chk("R11", 17);
    chk("R11", rd_a_data, 32'h1234_5678);
    cyc("R11", 1, 0, 0, 0, 0, 0, 0, 0);
    rd_chk("R11", 20);
    chk("R11", rd_a_data, 32'h0BAD_F00D);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule